// File: doc/BRIEF.md
# Dual-Die Access Steering

This block lets a host with a single memory-mapped port drive pairs of identical memory dies that all answer in one address range. Each word address falls in one of three windows: a boot RAM, a data buffer RAM or a register set. It can also fall outside all three. The block decides from that window, and from a die-select bit, which die of the addressed pair receives a strobe. The die-side address, write-enable and write-data lines are shared by every die. Each die has its own strobe. Read data from the chosen die comes back to the host one cycle after the request.

Register writes go to both dies of a pair at once, so the two register sets stay identical. That includes the start-address register, which holds the die-select bit. Boot RAM traffic always goes to the first die of the pair. After reset, the block asks each pair's first die to copy its boot image. It stalls host boot-RAM accesses until that die reports the copy is complete. With two or more pairs, one chip-enable input per pair picks the pair. Each pair has its own select bit and its own boot state.

Top module: `dual_die_steer`

## Requirements
- R1: Word addresses 0x0000–0x01FF are boot RAM, 0x0200–0x0FFF are data RAM and 0xF000–0xFFFF are registers. An access to any other address strobes no die. A read of such an address returns 0 with a valid strobe.
- R2: A boot RAM read or write strobes only the first die of the pair (die 2p for pair p), whatever the die-select bit holds.
- R3: After reset, copy_req[p] is high from the first cycle after the internal reset release until copy_done[p] is seen. boot_ready[p] stays low until then and stays high afterwards.
- R4: While boot_ready[p] is low, a boot RAM access to pair p raises host_wait, strobes no die and returns no read. Once the copy completes, the held access goes ahead.
- R5: A data RAM access strobes only die 2p+sel of pair p, where sel 0 names the first die and sel 1 names the second.
- R6: A register write strobes both dies of the pair in the same cycle, whatever sel holds.
- R7: A register read returns the value from die 2p+sel.
- R8: sel resets to 0. It is loaded from bit 0 of the write data only by a register write to word address 0xF100. Writes to any other address leave it unchanged.
- R9: An accepted read raises host_rvalid for one cycle, exactly one cycle after the request. Writes never raise host_rvalid.
- R10: host_ce[p] routes an access to pair p only. With no chip-enable high, no die is strobed. Pairs keep separate sel bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Host access request |
| host_ce | input | NPAIR | One chip-enable per die pair |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | DW | Write data |
| host_wait | output | 1 | Boot RAM access held while the copy runs |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | DW | Read data |
| die_cs | output | 2*NPAIR | Per-die strobe |
| die_we | output | 1 | Shared die write-enable |
| die_addr | output | AW | Shared die address |
| die_wdata | output | DW | Shared die write data |
| die_rdata | input | 2*NPAIR x DW | Per-die read data, one cycle after strobe |
| copy_req | output | NPAIR | Boot copy request to each pair's first die |
| copy_done | input | NPAIR | Boot copy finished, from each pair's first die |
| boot_ready | output | NPAIR | Boot RAM of the pair is usable |

## Verification
The bench sweeps the first and last word of every window, plus words just outside them. It does this for both values of sel on both pairs. A design that moved a window edge by one would strobe the wrong die, or return non-zero data for a hole. Register writes are checked for both strobes, and the start-address register is read back from the selected die. A design that honoured sel on writes would leave the two dies' copies different, and the read-back would fail after sel flips. A write to the neighbouring address 0xF101 and a data read on the untouched pair expose a select bit that decodes too loosely or is shared between pairs. A boot access issued during the copy must stall with no strobe and then finish. A design that let it through early would strobe die 0 while host_wait was still high.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_BOOT = 2'd1,
    RG_DATA = 2'd2,
    RG_REG  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    BS_IDLE  = 2'd0,
    BS_COPY  = 2'd1,
    BS_READY = 2'd2
  } boot_st_e;
endpackage

// File: rtl/dds_decode.sv
module dds_decode
  import dds_pkg::*;
#(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] BOOT_LAST  = 16'h01FF,
  parameter logic [AW-1:0] DATA_FIRST = 16'h0200,
  parameter logic [AW-1:0] DATA_LAST  = 16'h0FFF,
  parameter logic [AW-1:0] REG_FIRST  = 16'hF000,
  parameter logic [AW-1:0] SEL_ADDR   = 16'hF100
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic          is_sel
);
  always_comb begin
    region = RG_NONE;
    if (addr <= BOOT_LAST)                            region = RG_BOOT;
    else if (addr >= DATA_FIRST && addr <= DATA_LAST) region = RG_DATA;
    else if (addr >= REG_FIRST)                       region = RG_REG;
  end

  assign is_sel = (addr == SEL_ADDR);
endmodule

// File: rtl/dds_boot_seq.sv
module dds_boot_seq
  import dds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic copy_done,
  output logic copy_req,
  output logic boot_ready
);
  boot_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      BS_IDLE:  st_d = BS_COPY;
      BS_COPY:  if (copy_done) st_d = BS_READY;
      BS_READY: st_d = BS_READY;
      default:  st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BS_IDLE;
    else        st_q <= st_d;
  end

  assign copy_req   = (st_q == BS_COPY);
  assign boot_ready = (st_q == BS_READY);

  // R3: ready never drops once reached
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ready |=> boot_ready);
  // R3: request held until the die answers
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_req && !copy_done) |=> copy_req);
  // R3: request and ready never together
  a_r3_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(copy_req && boot_ready));
endmodule

// File: rtl/dds_pair.sv
module dds_pair
  import dds_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               we,
  input  region_e            region,
  input  logic               is_sel,
  input  logic               sel_wbit,
  input  logic [1:0][DW-1:0] die_rdata,
  input  logic               copy_done,
  output logic               copy_req,
  output logic               boot_ready,
  output logic               stall,
  output logic [1:0]         cs,
  output logic               rvalid,
  output logic [DW-1:0]      rdata
);
  logic go, sel_en, sel_q, sel_d;
  logic rd_pend_q, rd_pend_d, rd_die_q, rd_die_d, rd_zero_q, rd_zero_d;

  dds_boot_seq u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .copy_done  (copy_done),
    .copy_req   (copy_req),
    .boot_ready (boot_ready)
  );

  assign stall = acc && (region == RG_BOOT) && !boot_ready;
  assign go    = acc && !stall;

  // die strobes
  always_comb begin
    cs = 2'b00;
    if (go) begin
      case (region)
        RG_BOOT: cs = 2'b01;
        RG_DATA: cs = sel_q ? 2'b10 : 2'b01;
        RG_REG:  cs = we ? 2'b11 : (sel_q ? 2'b10 : 2'b01);
        default: cs = 2'b00;
      endcase
    end
  end

  // die-select bit, snooped from broadcast register writes
  assign sel_en = go && we && (region == RG_REG) && is_sel;
  always_comb begin
    sel_d = sel_q;
    if (sel_en) sel_d = sel_wbit;
  end

  // read return tracking
  always_comb begin
    rd_pend_d = go && !we;
    rd_die_d  = ((region == RG_DATA) || (region == RG_REG)) ? sel_q : 1'b0;
    rd_zero_d = (region == RG_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_die_q  <= 1'b0;
      rd_zero_q <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      rd_pend_q <= rd_pend_d;
      if (rd_pend_d) begin
        rd_die_q  <= rd_die_d;
        rd_zero_q <= rd_zero_d;
      end
    end
  end

  assign rvalid = rd_pend_q;
  assign rdata  = (rd_pend_q && !rd_zero_q) ? die_rdata[rd_die_q] : '0;

  // R4: a stalled access touches no die
  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (cs == 2'b00));
  // R4: a stalled access returns nothing
  a_r4_stall_noret: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !(acc && !we && !stall)) |=> !rvalid);
  // R6: register writes reach both dies
  a_r6_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && we && region == RG_REG) |-> (cs == 2'b11));
  // R2: boot traffic never reaches the second die
  a_r2_boot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && region == RG_BOOT) |-> !cs[1]);
  // R9: read answered in the next cycle
  a_r9_read_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !we && !stall) |=> rvalid);
  // R9: writes answer nothing
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && !we)) |=> !rvalid);
  // R8: sel moves only on a write to the start-address register
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && we && region == RG_REG && is_sel) |=> $stable(sel_q));
endmodule

// File: rtl/dual_die_steer.sv
module dual_die_steer
  import dds_pkg::*;
#(
  parameter int              NPAIR      = 2,
  parameter int              AW         = 16,
  parameter int              DW         = 16,
  parameter logic [AW-1:0]   BOOT_LAST  = 16'h01FF,
  parameter logic [AW-1:0]   DATA_FIRST = 16'h0200,
  parameter logic [AW-1:0]   DATA_LAST  = 16'h0FFF,
  parameter logic [AW-1:0]   REG_FIRST  = 16'hF000,
  parameter logic [AW-1:0]   SEL_ADDR   = 16'hF100,
  parameter int              SEL_BIT    = 0,
  localparam int             NDIE       = 2 * NPAIR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic [NPAIR-1:0]      host_ce,
  input  logic                  host_we,
  input  logic [AW-1:0]         host_addr,
  input  logic [DW-1:0]         host_wdata,
  output logic                  host_wait,
  output logic                  host_rvalid,
  output logic [DW-1:0]         host_rdata,
  output logic [NDIE-1:0]       die_cs,
  output logic                  die_we,
  output logic [AW-1:0]         die_addr,
  output logic [DW-1:0]         die_wdata,
  input  logic [NDIE-1:0][DW-1:0] die_rdata,
  output logic [NPAIR-1:0]      copy_req,
  input  logic [NPAIR-1:0]      copy_done,
  output logic [NPAIR-1:0]      boot_ready
);
  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  region_e                 region;
  logic                    is_sel;
  logic [NPAIR-1:0][1:0]   pair_cs;
  logic [NPAIR-1:0]        pair_stall, pair_rvalid;
  logic [NPAIR-1:0][DW-1:0] pair_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dds_decode #(
    .AW(AW), .BOOT_LAST(BOOT_LAST), .DATA_FIRST(DATA_FIRST),
    .DATA_LAST(DATA_LAST), .REG_FIRST(REG_FIRST), .SEL_ADDR(SEL_ADDR)
  ) u_dec (
    .addr   (host_addr),
    .region (region),
    .is_sel (is_sel)
  );

  for (genvar gp = 0; gp < NPAIR; gp++) begin : g_pair
    dds_pair #(.DW(DW)) u_pair (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .acc        (host_req && host_ce[gp]),
      .we         (host_we),
      .region     (region),
      .is_sel     (is_sel),
      .sel_wbit   (host_wdata[SEL_BIT]),
      .die_rdata  (die_rdata[2*gp+1 -: 2]),
      .copy_done  (copy_done[gp]),
      .copy_req   (copy_req[gp]),
      .boot_ready (boot_ready[gp]),
      .stall      (pair_stall[gp]),
      .cs         (pair_cs[gp]),
      .rvalid     (pair_rvalid[gp]),
      .rdata      (pair_rdata[gp])
    );
  end

  assign die_cs      = pair_cs;
  assign die_we      = host_we;
  assign die_addr    = host_addr;
  assign die_wdata   = host_wdata;
  assign host_wait   = |pair_stall;
  assign host_rvalid = |pair_rvalid;

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NPAIR; i++) host_rdata = host_rdata | pair_rdata[i];
  end

  // R1: holes in the map strobe nothing
  a_r1_hole_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (region == RG_NONE) |-> (die_cs == '0));
  // R10: no chip-enable, no strobe
  a_r10_no_ce: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_ce == '0) |-> (die_cs == '0));
endmodule

// File: tb/tb_dual_die_steer.sv
module tb_dual_die_steer;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 2;
  localparam int NDIE  = 4;

  logic clk, rst_n;
  logic host_req, host_we, host_wait, host_rvalid, die_we;
  logic [NPAIR-1:0] host_ce, copy_req, copy_done, boot_ready;
  logic [15:0] host_addr, host_wdata, host_rdata, die_addr, die_wdata;
  logic [NDIE-1:0] die_cs;
  logic [NDIE-1:0][15:0] die_rdata;
  logic cd0, cd1;
  assign copy_done = {cd1, cd0};

  int checks = 0, errors = 0;
  logic [15:0] dmem   [logic [17:0]];
  logic [15:0] shadow [logic [17:0]];
  logic [NPAIR-1:0] sel_m;

  dual_die_steer dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ce(host_ce),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wait(host_wait), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .die_cs(die_cs), .die_we(die_we), .die_addr(die_addr), .die_wdata(die_wdata),
    .die_rdata(die_rdata), .copy_req(copy_req), .copy_done(copy_done),
    .boot_ready(boot_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] dflt(int d, logic [15:0] a);
    return (16'h1357 * 16'(d + 1)) ^ a;
  endfunction

  // die models: synchronous RAM, read data one cycle after strobe
  always @(posedge clk) begin
    for (int d = 0; d < NDIE; d++) begin
      if (die_cs[d]) begin
        if (die_we) dmem[{2'(d), die_addr}] = die_wdata;
        else die_rdata[d] <= dmem.exists({2'(d), die_addr}) ?
                             dmem[{2'(d), die_addr}] : dflt(d, die_addr);
      end
    end
  end

  // boot copy responders
  initial begin
    cd0 = 1'b0;
    wait (copy_req[0] === 1'b1);
    repeat (12) @(posedge clk);
    @(negedge clk) cd0 = 1'b1;
    wait (copy_req[0] === 1'b0);
    @(negedge clk) cd0 = 1'b0;
  end
  initial begin
    cd1 = 1'b0;
    wait (copy_req[1] === 1'b1);
    repeat (30) @(posedge clk);
    @(negedge clk) cd1 = 1'b1;
    wait (copy_req[1] === 1'b0);
    @(negedge clk) cd1 = 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sh_get(int d, logic [15:0] a);
    return shadow.exists({2'(d), a}) ? shadow[{2'(d), a}] : dflt(d, a);
  endfunction

  // one host access to pair p, with expectations from the requirements
  task automatic access(int p, logic we, logic [15:0] a, logic [15:0] wd);
    int rg; // 0 none, 1 boot, 2 data, 3 reg
    int d;
    logic [3:0] exp_cs;
    string tag;
    logic [15:0] exp_rd;
    if (a <= 16'h01FF) rg = 1;
    else if (a >= 16'h0200 && a <= 16'h0FFF) rg = 2;
    else if (a >= 16'hF000) rg = 3;
    else rg = 0;
    d = (rg == 1) ? 2*p : 2*p + int'(sel_m[p]);
    exp_cs = '0;
    if (rg == 1 || rg == 2) exp_cs[d] = 1'b1;
    if (rg == 3) begin
      if (we) begin exp_cs[2*p] = 1'b1; exp_cs[2*p+1] = 1'b1; end
      else exp_cs[d] = 1'b1;
    end
    case (rg)
      0: tag = "R1";
      1: tag = "R2";
      2: tag = "R5";
      default: tag = we ? "R6" : "R7";
    endcase
    exp_rd = (rg == 0) ? 16'h0 : sh_get(d, a);
    @(negedge clk);
    host_req = 1'b1; host_ce = 2'(1 << p); host_we = we;
    host_addr = a; host_wdata = wd;
    #1;
    chk(tag, 32'(die_cs), 32'(exp_cs));
    if (we && rg != 0) begin
      if (rg == 3) begin
        shadow[{2'(2*p), a}] = wd;
        shadow[{2'(2*p+1), a}] = wd;
        if (a == 16'hF100) sel_m[p] = wd[0];
      end else shadow[{2'(d), a}] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0; host_ce = '0;
    #1;
    chk("R9", 32'(host_rvalid), 32'(!we));
    if (!we) chk(tag, 32'(host_rdata), 32'(exp_rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrs [10];
    int n;
    addrs = '{16'h0000, 16'h0100, 16'h01FF, 16'h0200, 16'h0800,
              16'h0FFF, 16'h1000, 16'hEFFF, 16'hF000, 16'hFFFF};
    sel_m = '0;
    host_req = 1'b0; host_ce = '0; host_we = 1'b0;
    host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3", 32'(boot_ready), 32'h0);
    chk("R3", 32'(copy_req), 32'h0);
    chk("R9", 32'(host_rvalid), 32'h0);
    chk("R10", 32'(die_cs), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", 32'(copy_req), 32'h3);
    chk("R3", 32'(boot_ready), 32'h0);

    // R4: boot access during copy stalls, then completes
    host_req = 1'b1; host_ce = 2'b01; host_we = 1'b0; host_addr = 16'h0010;
    #1;
    chk("R4", 32'(host_wait), 32'h1);
    chk("R4", 32'(die_cs), 32'h0);
    n = 0;
    while (host_wait === 1'b1 && n < 200) begin
      @(posedge clk); @(negedge clk); #1;
      if (host_wait === 1'b1) chk("R4", 32'(host_rvalid | die_cs[0]), 32'h0);
      n++;
    end
    chk("R4", 32'(host_wait), 32'h0);
    chk("R4", 32'(die_cs), 32'h1);
    chk("R3", 32'(boot_ready[0]), 32'h1);
    @(posedge clk); @(negedge clk);
    host_req = 1'b0; host_ce = '0; #1;
    chk("R4", 32'(host_rvalid), 32'h1);
    chk("R4", 32'(host_rdata), 32'(dflt(0, 16'h0010)));

    n = 0;
    while (boot_ready !== 2'b11 && n < 200) begin @(negedge clk); n++; end
    chk("R3", 32'(boot_ready), 32'h3);
    chk("R3", 32'(copy_req), 32'h0);

    // R8: select bit resets to 0 on both pairs
    access(0, 1'b0, 16'h0300, 16'h0);
    access(1, 1'b0, 16'h0300, 16'h0);

    for (int p = 0; p < NPAIR; p++) begin
      if (p == 1) begin
        // R10: pair 0 sel is 1 now, pair 1 must still read its first die
        chk("R10", 32'(sel_m[1]), 32'h0);
        access(1, 1'b0, 16'h0400, 16'h0);
      end
      for (int s = 0; s < 2; s++) begin
        access(p, 1'b1, 16'hF100, 16'(s));     // R6, R8
        access(p, 1'b0, 16'hF100, 16'h0);      // R7 read-back
        for (int i = 0; i < 10; i++) begin
          access(p, 1'b1, addrs[i], {4'(p), 4'(s), 8'(i)} ^ 16'hA5C3);
          access(p, 1'b0, addrs[i], 16'h0);
        end
        // R8: neighbour address does not load sel
        access(p, 1'b1, 16'hF101, 16'(!sel_m[p]));
        access(p, 1'b0, 16'h0A00, 16'h0);
      end
    end

    // R10: request with no chip-enable
    @(negedge clk);
    host_req = 1'b1; host_ce = '0; host_we = 1'b0; host_addr = 16'h0200; #1;
    chk("R10", 32'(die_cs), 32'h0);
    @(posedge clk); @(negedge clk);
    host_req = 1'b0; #1;
    chk("R10", 32'(host_rvalid), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule